// File: doc/BRIEF.md
# Dual-Channel Compare Match Interval Timer

This block holds two independent 16-bit interval timers behind one small word-addressed register port. Each channel picks one of four fixed divisions of the peripheral clock (by 4, 8, 16 or 64) from a free-running 6-bit prescaler that both channels share. When a channel's run bit is set, its up-counter advances by one on every strobe of the chosen tap. When the count equals the channel's compare constant, the next tick returns the counter to zero, so one match occurs every (constant + 1) ticks.

Each match sets a per-channel match flag. A per-channel mode bit decides where the event goes. In interrupt mode, a level request is driven while the flag is set and interrupts are enabled. In DMA mode, a one-cycle transfer request pulse is driven instead, and the DMA acknowledge clears the flag. Software clears the flag with a read-then-write sequence. A module-stop input freezes the prescaler and both counters to save power, and the registers stay writable while it is asserted.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, all four registers of each channel read as follows: run bit 0, control 0, counter 0, constant 0xFFFF. Both irqReq and dmaReq are low.
- R2: The control field bits [1:0] select the count tick: 00 gives one tick every 4 clocks, 01 every 8, 10 every 16 and 11 every 64. All taps come from one shared 6-bit prescaler that starts at 0 after reset and counts on every clock. A tap fires on the cycle in which the low log2(N) prescaler bits are all ones.
- R3: While a channel's run bit is 1, its counter increases by one on each tick. While the run bit is 0, the counter holds its value.
- R4: When a tick arrives and the counter equals the constant, the counter becomes 0 and the match flag (control bit 7) is set at the same clock edge. Matches therefore recur every (constant + 1) ticks.
- R5: Writing 0 to control bit 7 clears the flag only if control was read (rdEn high) with the flag at 1 since the last control write. Otherwise the flag is kept. Writing 1 to bit 7 never sets it. A new match wins over a clear in the same cycle.
- R6: irqReq of a channel is high exactly while its flag is 1, its interrupt enable (control bit 2) is 1 and its DMA mode bit (control bit 3) is 0.
- R7: With control bit 3 set, each match drives dmaReq high for one cycle, in the cycle after the matching edge. dmaAck high at a clock edge clears that channel's flag.
- R8: A write to the counter register loads the written value and takes priority over an increment in the same cycle. A match is suppressed in that cycle.
- R9: While modStop is 1, the prescaler and both counters hold their values (except for software counter writes), and no match occurs.
- R10: The two channels count, match and request independently, each with its own tap, constant and mode.
- R11: addr[2] selects the channel and addr[1:0] selects the register: 0 is the run bit (bit 0), 1 is control, 2 is the counter and 3 is the constant. Unused control bits read 0. rdData shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| modStop | input | 1 | Freezes prescaler and counters when high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 3 | Channel (bit 2) and register offset (bits 1:0) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed register |
| dmaAck | input | 2 | Per-channel DMA acknowledge |
| irqReq | output | 2 | Per-channel interrupt request level |
| dmaReq | output | 2 | Per-channel single-cycle DMA request |

## Verification
The bench tries the counter with a small constant under each of the four taps. Cycle-exact agreement with the reference model distinguishes the tap encodings and any off-by-one in the wrap period. One channel runs in interrupt mode while the other runs in DMA mode with acknowledges. This separates per-channel state from shared state, and shows whether the level and pulse outputs follow their own mode bit. Directed sequences cover the following:
- a flag clear attempted without a prior read, and then with one;
- counter writes that collide with increments and with the matching value;
- a module-stop window.

Each of these tells apart the ordering rules, not just the basic counting.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int NumChan  = 2;
  localparam int CntWidth = 16;
  localparam int PscWidth = 6;
  localparam int NumTaps  = 4;
  localparam int SelWidth = $clog2(NumTaps);

  localparam int BitIrqEn = 2;
  localparam int BitDma   = 3;
  localparam int BitFlag  = 7;

  typedef enum logic [1:0] {
    OffRun   = 2'd0,
    OffCtrl  = 2'd1,
    OffCnt   = 2'd2,
    OffConst = 2'd3
  } regOffT;

  // strobes and settings handed from control to datapath, one per channel
  typedef struct packed {
    logic                run;
    logic [SelWidth-1:0] clkSel;
    logic                irqEn;
    logic                dmaMode;
    logic                cntWr;
    logic                flagClr;
    logic [CntWidth-1:0] constVal;
  } chanStrobeT;

  // log2 of the division ratio of each prescaler tap
  function automatic int tapExp(int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler
  import dit_pkg::*;
#(
  parameter int PW = PscWidth,
  parameter int NT = NumTaps
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modStop,
  output logic [NT-1:0] tapStrb
);
  logic [PW-1:0] pscQ;

  always_ff @(posedge clk) begin
    if (!rstN)         pscQ <= '0;
    else if (!modStop) pscQ <= pscQ + PW'(1);
  end

  for (genvar g = 0; g < NT; g++) begin : gTap
    localparam int E = tapExp(g);
    assign tapStrb[g] = !modStop && (&pscQ[E-1:0]);
  end
endmodule

// File: rtl/dit_control.sv
module dit_control
  import dit_pkg::*;
#(
  parameter int NCH = NumChan,
  parameter int CW  = CntWidth,
  localparam int ChW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = ChW + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [AW-1:0]            addr,
  input  logic [CW-1:0]            wrData,
  input  logic [NCH-1:0]           flag,
  input  logic [NCH-1:0][CW-1:0]   cntVal,
  output chanStrobeT [NCH-1:0]     strb,
  output logic [CW-1:0]            rdData
);
  logic [ChW-1:0] chIdx;
  regOffT         off;
  assign chIdx = addr[AW-1:2];
  assign off   = regOffT'(addr[1:0]);

  logic [NCH-1:0]               runQ, ienQ, dmaQ, armQ;
  logic [NCH-1:0][SelWidth-1:0] selQ;
  logic [NCH-1:0][CW-1:0]       constQ;
  logic [NCH-1:0]               wrRun, wrCtrl, wrCnt, wrConst, rdCtrl;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wrRun[i]   = wrEn && chIdx == ChW'(i) && off == OffRun;
      wrCtrl[i]  = wrEn && chIdx == ChW'(i) && off == OffCtrl;
      wrCnt[i]   = wrEn && chIdx == ChW'(i) && off == OffCnt;
      wrConst[i] = wrEn && chIdx == ChW'(i) && off == OffConst;
      rdCtrl[i]  = rdEn && chIdx == ChW'(i) && off == OffCtrl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= '0;
      ienQ   <= '0;
      dmaQ   <= '0;
      armQ   <= '0;
      selQ   <= '0;
      constQ <= {NCH{ {CW{1'b1}} }};
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wrRun[i]) runQ[i] <= wrData[0];
        if (wrCtrl[i]) begin
          selQ[i] <= wrData[SelWidth-1:0];
          ienQ[i] <= wrData[BitIrqEn];
          dmaQ[i] <= wrData[BitDma];
        end
        if (wrConst[i]) constQ[i] <= wrData;
        if (wrCtrl[i])                 armQ[i] <= 1'b0;
        else if (rdCtrl[i] && flag[i]) armQ[i] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gStrb
    assign strb[g].run      = runQ[g];
    assign strb[g].clkSel   = selQ[g];
    assign strb[g].irqEn    = ienQ[g];
    assign strb[g].dmaMode  = dmaQ[g];
    assign strb[g].cntWr    = wrCnt[g];
    assign strb[g].flagClr  = wrCtrl[g] && !wrData[BitFlag] && armQ[g];
    assign strb[g].constVal = constQ[g];
  end

  always_comb begin
    rdData = '0;
    case (off)
      OffRun:   rdData[0] = runQ[chIdx];
      OffCtrl: begin
        rdData[SelWidth-1:0] = selQ[chIdx];
        rdData[BitIrqEn]     = ienQ[chIdx];
        rdData[BitDma]       = dmaQ[chIdx];
        rdData[BitFlag]      = flag[chIdx];
      end
      OffCnt:   rdData = cntVal[chIdx];
      OffConst: rdData = constQ[chIdx];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dit_datapath.sv
module dit_datapath
  import dit_pkg::*;
#(
  parameter int NCH = NumChan,
  parameter int CW  = CntWidth,
  parameter int NT  = NumTaps
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NT-1:0]          tapStrb,
  input  chanStrobeT [NCH-1:0]   strb,
  input  logic [CW-1:0]          wrData,
  input  logic [NCH-1:0]         dmaAck,
  output logic [NCH-1:0][CW-1:0] cntVal,
  output logic [NCH-1:0]         flag,
  output logic [NCH-1:0]         irqReq,
  output logic [NCH-1:0]         dmaReq
);
  for (genvar g = 0; g < NCH; g++) begin : gChan
    logic [CW-1:0] cntQ;
    logic          flagQ, pulseQ;
    logic          tick, hit, matchEvt;

    assign tick     = strb[g].run && tapStrb[strb[g].clkSel];
    assign hit      = cntQ == strb[g].constVal;
    assign matchEvt = tick && hit && !strb[g].cntWr;

    always_ff @(posedge clk) begin
      if (!rstN)              cntQ <= '0;
      else if (strb[g].cntWr) cntQ <= wrData;
      else if (tick)          cntQ <= hit ? '0 : cntQ + CW'(1);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ  <= 1'b0;
        pulseQ <= 1'b0;
      end else begin
        if (matchEvt)                           flagQ <= 1'b1;
        else if (strb[g].flagClr || dmaAck[g])  flagQ <= 1'b0;
        pulseQ <= matchEvt && strb[g].dmaMode;
      end
    end

    assign cntVal[g] = cntQ;
    assign flag[g]   = flagQ;
    assign irqReq[g] = flagQ && strb[g].irqEn && !strb[g].dmaMode;
    assign dmaReq[g] = pulseQ;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modStop,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic [1:0]  dmaAck,
  output logic [1:0]  irqReq,
  output logic [1:0]  dmaReq
);
  logic [NumTaps-1:0]                tapStrb;
  chanStrobeT [NumChan-1:0]          strb;
  logic [NumChan-1:0][CntWidth-1:0]  cntVal;
  logic [NumChan-1:0]                flag;

  dit_prescaler #(.PW(PscWidth), .NT(NumTaps)) u_psc (
    .clk(clk), .rstN(rstN), .modStop(modStop), .tapStrb(tapStrb)
  );

  dit_control #(.NCH(NumChan), .CW(CntWidth)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .flag(flag), .cntVal(cntVal), .strb(strb), .rdData(rdData)
  );

  dit_datapath #(.NCH(NumChan), .CW(CntWidth), .NT(NumTaps)) u_dp (
    .clk(clk), .rstN(rstN), .tapStrb(tapStrb), .strb(strb), .wrData(wrData),
    .dmaAck(dmaAck), .cntVal(cntVal), .flag(flag), .irqReq(irqReq), .dmaReq(dmaReq)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
(
  input logic                             clk,
  input logic                             rstN,
  input logic                             modStop,
  input chanStrobeT [NumChan-1:0]         strb,
  input logic [NumChan-1:0][CntWidth-1:0] cntVal,
  input logic [NumChan-1:0]               flag,
  input logic [NumChan-1:0]               irqReq,
  input logic [NumChan-1:0]               dmaReq
);
  for (genvar g = 0; g < NumChan; g++) begin : gChk
    assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!$stable(cntVal[g]) && !$past(strb[g].cntWr) && cntVal[g] != '0)
        |-> cntVal[g] == $past(cntVal[g]) + CntWidth'(1));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flag[g]) |-> cntVal[g] == '0);

    assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
      irqReq[g] |-> flag[g]);

    assert_dma_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
      dmaReq[g] |=> !dmaReq[g]);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
      (modStop && !strb[g].cntWr) |=> $stable(cntVal[g]));
  end
endmodule

bind dual_interval_timer dit_checker u_chk (
  .clk(clk), .rstN(rstN), .modStop(modStop), .strb(strb),
  .cntVal(cntVal), .flag(flag), .irqReq(irqReq), .dmaReq(dmaReq)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modStop = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  dmaAck = '0;
  logic [1:0]  irqReq;
  logic [1:0]  dmaReq;

  int    nTests = 0;
  int    nFail  = 0;
  string curTag = "R1";
  bit    autoAck = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  dual_interval_timer u_dual_interval_timer (
    .clk(clk), .rstN(rstN), .modStop(modStop), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .dmaAck(dmaAck),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  // behavioural reference model
  int psc;
  int mCnt[2], mCst[2], mSel[2];
  bit mRun[2], mFlag[2], mArm[2], mIen[2], mDma[2], mPulse[2];

  always @(posedge clk) begin
    if (!rstN) begin
      psc = 0;
      for (int c = 0; c < 2; c++) begin
        mCnt[c] = 0; mCst[c] = 65535; mSel[c] = 0;
        mRun[c] = 0; mFlag[c] = 0; mArm[c] = 0; mIen[c] = 0; mDma[c] = 0; mPulse[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int  div;
        bit  tick, wCnt, wCtl, match, clr;
        div   = (mSel[c] == 0) ? 4 : (mSel[c] == 1) ? 8 : (mSel[c] == 2) ? 16 : 64;
        tick  = !modStop && mRun[c] && ((psc % div) == div - 1);
        wCnt  = wrEn && addr == 3'(c * 4 + 2);
        wCtl  = wrEn && addr == 3'(c * 4 + 1);
        match = tick && !wCnt && mCnt[c] == mCst[c];
        clr   = (wCtl && !wrData[7] && mArm[c]) || dmaAck[c];
        mPulse[c] = match && mDma[c];
        if (wCtl) mArm[c] = 0;
        else if (rdEn && addr == 3'(c * 4 + 1) && mFlag[c]) mArm[c] = 1;
        if (match) mFlag[c] = 1;
        else if (clr) mFlag[c] = 0;
        if (wCnt) mCnt[c] = int'(wrData);
        else if (tick) mCnt[c] = (mCnt[c] == mCst[c]) ? 0 : mCnt[c] + 1;
        if (wCtl) begin
          mSel[c] = int'(wrData[1:0]); mIen[c] = wrData[2]; mDma[c] = wrData[3];
        end
        if (wrEn && addr == 3'(c * 4)) mRun[c] = wrData[0];
        if (wrEn && addr == 3'(c * 4 + 3)) mCst[c] = int'(wrData);
      end
      if (!modStop) psc = (psc + 1) % 64;
    end
  end

  function automatic logic [15:0] expRead(logic [2:0] a);
    int c;
    logic [15:0] v;
    c = int'(a[2]);
    v = '0;
    case (a[1:0])
      2'd0: v[0] = mRun[c];
      2'd1: begin v[1:0] = 2'(mSel[c]); v[2] = mIen[c]; v[3] = mDma[c]; v[7] = mFlag[c]; end
      2'd2: v = 16'(mCnt[c]);
      default: v = 16'(mCst[c]);
    endcase
    return v;
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, shortly before the rising edge
  always @(negedge clk) begin
    #3;
    if (rstN && !done) begin
      check(curTag, "rdData", rdData, expRead(addr));
      for (int c = 0; c < 2; c++) begin
        check("R6", "irqReq", 16'(irqReq[c]), 16'(mFlag[c] && mIen[c] && !mDma[c]));
        check("R7", "dmaReq", 16'(dmaReq[c]), 16'(mPulse[c]));
      end
    end
  end

  always @(negedge clk) dmaAck = autoAck ? dmaReq : 2'b00;

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, int n);
    @(negedge clk);
    addr = a;
    idle(n);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        nFail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nTests, nFail);
        $finish;
      end
    end
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    // R1: reset values on every address
    curTag = "R1";
    for (int a = 0; a < 8; a++) peek(3'(a), 1);
    // R11: address map and field positions
    curTag = "R11";
    wr(3'd3, 16'h1234);
    wr(3'd7, 16'h0ABC);
    wr(3'd5, 16'h00FB);
    for (int a = 0; a < 8; a++) peek(3'(a), 1);
    wr(3'd5, 16'h0000);
    // R3 and R4: channel 0, tap /4, constant 5, interrupt enabled
    curTag = "R3";
    wr(3'd3, 16'd5);
    wr(3'd1, 16'h0004);
    wr(3'd0, 16'h0001);
    peek(3'd2, 40);
    curTag = "R4";
    peek(3'd1, 30);
    // R5: flag clear protocol
    curTag = "R5";
    wr(3'd0, 16'h0000);
    idle(30);
    wr(3'd1, 16'h0084);
    peek(3'd1, 3);
    wr(3'd1, 16'h0004);
    peek(3'd1, 3);
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    wr(3'd1, 16'h0004);
    peek(3'd1, 3);
    // R8: counter writes while running
    curTag = "R8";
    wr(3'd0, 16'h0001);
    peek(3'd2, 3);
    wr(3'd2, 16'd3);
    idle(2);
    wr(3'd2, 16'd5);
    idle(5);
    for (int i = 0; i < 12; i++) wr(3'd2, 16'd5);
    peek(3'd1, 2);
    peek(3'd2, 20);
    // R2: other taps on channel 0, constant 3
    curTag = "R2";
    wr(3'd3, 16'd3);
    wr(3'd1, 16'h0005);
    peek(3'd2, 100);
    wr(3'd1, 16'h0006);
    peek(3'd2, 150);
    wr(3'd1, 16'h0007);
    peek(3'd2, 300);
    // R7 and R10: channel 1 in DMA mode alongside channel 0
    curTag = "R10";
    wr(3'd1, 16'h0004);
    wr(3'd7, 16'd2);
    wr(3'd5, 16'h000F);
    wr(3'd4, 16'h0001);
    autoAck = 1'b1;
    peek(3'd6, 250);
    curTag = "R7";
    peek(3'd5, 250);
    autoAck = 1'b0;
    peek(3'd5, 300);
    // R9: module stop freezes counting
    curTag = "R9";
    peek(3'd2, 5);
    modStop = 1'b1;
    idle(60);
    wr(3'd6, 16'd1);
    peek(3'd6, 20);
    modStop = 1'b0;
    peek(3'd2, 40);
    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule